// File: doc/BRIEF.md
# Matrix Keypad Column Scanner

This block connects a 4x4 switch matrix to a processor. Four column lines are outputs and four row lines are inputs with pull-ups. While no scan runs, every column is driven low, so a press on any key pulls its row low. The board combines the rows into one active-low "any key" line. A falling edge on that line is how the block learns that a key went down.

On such an edge the block raises a strobe flag and starts a scan. The flag can also drive an interrupt. The scan pulls one column low at a time and waits a programmable settle time. It then samples the synchronized rows. The first column with a low row ends the scan, and the row and column nibbles are latched together as a raw 8-bit key code. If no column shows a low row, the scan ends with a "no key" status. In both cases the columns go back to all low.

Software uses four registers: status/control, key data, settle count and column direction. The flag is cleared by reading status and then data, in that order.

Top module: `kpd_scan_top`

## Requirements
- R1: After reset, `col_o` is 0000, `col_oe_o` is 0000 and `irq_o` is 0. Address 0 reads 0x00, address 1 reads 0xFF and the settle register (address 2) reads 4.
- R2: While no scan runs, all four column outputs are low. `col_oe_o` equals bits [3:0] of the direction register at address 3, which reads back with bits [7:4] as zero.
- R3: A falling edge on `strobe_n_i` while idle sets the strobe flag (address 0 bit 7) and the busy bit (address 0 bit 4). Both are visible 3 clock edges after the edge is applied: two synchronizer stages, then one edge-detect stage.
- R4: `irq_o` is high exactly when the strobe flag and the interrupt enable (address 0 bit 0, read/write) are both 1.
- R5: The flag clears only when a read of address 1 follows a read of address 0 made while the flag was set. A read of address 1 on its own leaves the flag set.
- R6: Scan step s (s = 0..3) drives `col_o` bit 3-s low and the other three bits high, so step 0 drives 0111. Each step lasts settle+1 clocks, and settle must be at least 2.
- R7: The first step that sees any row low ends the scan. The data register then holds {rows[3:0], columns[3:0]}, key-found is set (address 0 bit 6) and busy clears. For a key in step c this happens 3+(c+1)(settle+1) edges after the strobe edge.
- R8: If no row is low in any of the four steps, the scan ends after 3+4(settle+1) edges. No-key (address 0 bit 5) is set, the data register keeps its old value and the columns return to all low.
- R9: Strobe edges that arrive during a scan do not set the flag and do not restart or stretch the scan.
- R10: Starting a scan clears the key-found and no-key bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register address: 0 status/control, 1 key data, 2 settle, 3 direction |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_rd | input | 1 | Read strobe; applies read side effects at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_sel` |
| col_o | output | 4 | Column drive levels |
| col_oe_o | output | 4 | Column output enables from the direction register |
| row_i | input | 4 | Row levels from the matrix, asynchronous |
| strobe_n_i | input | 1 | Combined active-low any-key line, asynchronous |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The bench applies each strobe edge just after a falling clock edge and counts rising edges from that moment. Busy must become visible 3 edges later. Completion must appear 3+(c+1)(settle+1) edges later for a key in step c, or 3+4(settle+1) for an empty scan. The bench then checks the exact edge count at the first falling edge where busy reads low. Flag, interrupt and code are read one half period after an edge, never at it. The rows come from a key model that reacts to the live column outputs, so the two synchronizer stages that the settle count must cover are exercised in every step.

// File: rtl/kpd_pkg.sv
// Shared constants for the keypad scanner: register addresses, status bit
// positions and the scan state type. Assumes an 8-bit register interface.
package kpd_pkg;
    localparam int RW = 8;

    localparam logic [1:0] ADR_STAT   = 2'd0;
    localparam logic [1:0] ADR_DATA   = 2'd1;
    localparam logic [1:0] ADR_SETTLE = 2'd2;
    localparam logic [1:0] ADR_DIR    = 2'd3;

    localparam int STB_IEN   = 0;
    localparam int STB_BUSY  = 4;
    localparam int STB_NOKEY = 5;
    localparam int STB_KEY   = 6;
    localparam int STB_FLAG  = 7;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } scan_st_t;
endpackage

// File: rtl/kpd_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes STAGES >= 2. The flops reset to RST_VAL, which is the idle level of the inputs.
module kpd_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int TOT = W * STAGES;

    logic [TOT-1:0] shreg;

    // Shift the input through STAGES flop ranks.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[TOT-W-1:0], d};
    end

    assign q = shreg[TOT-1 -: W];
endmodule

// File: rtl/kpd_scan_fsm.sv
// Column scan sequencer. When start is seen in idle, it steps through columns 0..NCOL-1.
// Step s pulls column bit NCOL-1-s low. The sequencer waits settle clocks, then samples
// the synchronized rows. It pulses hit with the raw code, or none after the last step.
// Assumes settle covers the row synchronizer delay.
module kpd_scan_fsm #(
    parameter int NCOL     = 4,
    parameter int NROW     = 4,
    parameter int SETTLE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NROW-1:0]      rows_s,
    input  logic [SETTLE_W-1:0]  settle,
    output logic [NCOL-1:0]      col_o,
    output logic                 busy,
    output logic                 hit,
    output logic                 none,
    output logic [NROW+NCOL-1:0] code
);
    import kpd_pkg::*;

    localparam int SW = (NCOL > 1) ? $clog2(NCOL) : 1;
    localparam logic [SW-1:0] LAST = SW'(NCOL - 1);

    scan_st_t              st_q;
    logic [SW-1:0]         step_q;
    logic [SETTLE_W-1:0]   cnt_q;
    logic                  sample;
    logic                  any_low;

    assign busy    = (st_q == ST_SETTLE);
    assign sample  = busy && (cnt_q == '0);
    assign any_low = (rows_s != '1);
    assign hit     = sample && any_low;
    assign none    = sample && !any_low && (step_q == LAST);
    assign code    = {rows_s, col_o};

    // One column driver per line: low when idle or when this line's step is active.
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign col_o[c] = busy && (step_q != SW'(NCOL - 1 - c));
    end

    // Scan state, step index and settle countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_SETTLE;
                        step_q <= '0;
                        cnt_q  <= settle;
                    end
                end
                default: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (any_low || step_q == LAST) begin
                        st_q   <= ST_IDLE;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                        cnt_q  <= settle;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/kpd_regs.sv
// Register file: status/control, key data, settle and direction.
// Holds the strobe flag and its two-read clear sequence, plus the scan result bits.
// Assumes one-clock reg_rd and reg_wr strobes. Read data is combinational from reg_sel.
module kpd_regs #(
    parameter int                 NCOL       = 4,
    parameter int                 NROW       = 4,
    parameter int                 SETTLE_W   = 8,
    parameter logic [SETTLE_W-1:0] SETTLE_RST = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [kpd_pkg::RW-1:0] reg_wdata,
    output logic [kpd_pkg::RW-1:0] reg_rdata,
    input  logic                 accept,
    input  logic                 hit,
    input  logic                 none,
    input  logic                 busy,
    input  logic [NROW+NCOL-1:0] code,
    output logic                 flag_q,
    output logic                 ien_q,
    output logic                 keyv_q,
    output logic [SETTLE_W-1:0]  settle_q,
    output logic [NCOL-1:0]      dir_q,
    output logic [NROW+NCOL-1:0] data_q
);
    import kpd_pkg::*;

    logic armed_q;
    logic nokey_q;
    logic rd_stat;
    logic rd_data;

    assign rd_stat = reg_rd && (reg_sel == ADR_STAT);
    assign rd_data = reg_rd && (reg_sel == ADR_DATA);

    // Software-writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q    <= 1'b0;
            settle_q <= SETTLE_RST;
            dir_q    <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                ADR_STAT:   ien_q    <= reg_wdata[STB_IEN];
                ADR_SETTLE: settle_q <= reg_wdata[SETTLE_W-1:0];
                ADR_DIR:    dir_q    <= reg_wdata[NCOL-1:0];
                default:    ;
            endcase
        end
    end

    // Strobe flag: set wins over the status-then-data clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (accept)                       flag_q <= 1'b1;
            else if (rd_data && armed_q)      flag_q <= 1'b0;
            if (rd_stat && flag_q)            armed_q <= 1'b1;
            else if (rd_data)                 armed_q <= 1'b0;
        end
    end

    // Scan result status and latched raw code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keyv_q  <= 1'b0;
            nokey_q <= 1'b0;
            data_q  <= '1;
        end else if (accept) begin
            keyv_q  <= 1'b0;
            nokey_q <= 1'b0;
        end else if (hit) begin
            keyv_q  <= 1'b1;
            data_q  <= code;
        end else if (none) begin
            nokey_q <= 1'b1;
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            ADR_STAT: begin
                reg_rdata[STB_IEN]   = ien_q;
                reg_rdata[STB_BUSY]  = busy;
                reg_rdata[STB_NOKEY] = nokey_q;
                reg_rdata[STB_KEY]   = keyv_q;
                reg_rdata[STB_FLAG]  = flag_q;
            end
            ADR_DATA:   reg_rdata = RW'(data_q);
            ADR_SETTLE: reg_rdata = RW'(settle_q);
            default:    reg_rdata = RW'(dir_q);
        endcase
    end
endmodule

// File: rtl/kpd_scan_top.sv
// Keypad scanner top. Synchronizes the any-key strobe and the rows, and detects strobe
// falling edges, which are accepted only while idle. Wires the sequencer and the registers.
// The interrupt is the flag gated by its enable.
module kpd_scan_top #(
    parameter int NCOL       = 4,
    parameter int NROW       = 4,
    parameter int SETTLE_W   = 8,
    parameter int SETTLE_RST = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              reg_sel,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [kpd_pkg::RW-1:0]  reg_wdata,
    output logic [kpd_pkg::RW-1:0]  reg_rdata,
    output logic [NCOL-1:0]         col_o,
    output logic [NCOL-1:0]         col_oe_o,
    input  logic [NROW-1:0]         row_i,
    input  logic                    strobe_n_i,
    output logic                    irq_o
);
    logic [NROW-1:0]         rows_s;
    logic                    strobe_s;
    logic                    strobe_prev_q;
    logic                    accept;
    logic                    scan_busy;
    logic                    scan_hit;
    logic                    scan_none;
    logic [NROW+NCOL-1:0]    scan_code;
    logic                    strobe_flag;
    logic                    irq_en;
    logic                    key_valid;
    logic [SETTLE_W-1:0]     settle;
    logic [NCOL-1:0]         dir;
    logic [NROW+NCOL-1:0]    data_q;

    kpd_sync #(.W(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_strobe_sync (
        .clk(clk), .rst_n(rst_n), .d(strobe_n_i), .q(strobe_s)
    );

    kpd_sync #(.W(NROW), .STAGES(SYNC_STG), .RST_VAL({NROW{1'b1}})) u_row_sync (
        .clk(clk), .rst_n(rst_n), .d(row_i), .q(rows_s)
    );

    // Previous synchronized strobe level, for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev_q <= 1'b1;
        else        strobe_prev_q <= strobe_s;
    end

    assign accept = strobe_prev_q && !strobe_s && !scan_busy;

    kpd_scan_fsm #(.NCOL(NCOL), .NROW(NROW), .SETTLE_W(SETTLE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(accept), .rows_s(rows_s), .settle(settle),
        .col_o(col_o), .busy(scan_busy), .hit(scan_hit), .none(scan_none), .code(scan_code)
    );

    kpd_regs #(.NCOL(NCOL), .NROW(NROW), .SETTLE_W(SETTLE_W),
               .SETTLE_RST(SETTLE_W'(SETTLE_RST))) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .accept(accept), .hit(scan_hit),
        .none(scan_none), .busy(scan_busy), .code(scan_code), .flag_q(strobe_flag),
        .ien_q(irq_en), .keyv_q(key_valid), .settle_q(settle), .dir_q(dir), .data_q(data_q)
    );

    assign col_oe_o = dir;
    assign irq_o    = strobe_flag && irq_en;
endmodule

// File: rtl/kpd_scan_chk.sv
// Assertion checker for kpd_scan_top, attached by bind. It observes ports and internal state only.
module kpd_scan_chk #(
    parameter int NCOL = 4,
    parameter int NROW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCOL-1:0]      col_o,
    input logic                 irq_o,
    input logic                 reg_rd,
    input logic [1:0]           reg_sel,
    input logic                 busy,
    input logic                 flag,
    input logic                 ien,
    input logic                 keyv,
    input logic [NROW+NCOL-1:0] data
);
    p_idle_cols_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (col_o == '0));

    p_one_col_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(col_o) == NCOL - 1));

    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag && ien));

    p_irq_raised_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ien) |-> irq_o);

    p_code_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(keyv) |-> ($countones(data[NCOL-1:0]) == NCOL - 1 &&
                         $countones(data[NROW+NCOL-1:NCOL]) == NROW - 1));

    p_flag_only_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $rose(busy));

    p_clear_by_data_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(reg_rd && reg_sel == kpd_pkg::ADR_DATA));
endmodule

bind kpd_scan_top kpd_scan_chk #(.NCOL(NCOL), .NROW(NROW)) u_chk (
    .clk(clk), .rst_n(rst_n), .col_o(col_o), .irq_o(irq_o), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .busy(scan_busy), .flag(strobe_flag), .ien(irq_en),
    .keyv(key_valid), .data(data_q)
);

// File: tb/sim_kpd_scan_top.sv
module sim_kpd_scan_top;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] col_o;
    logic [3:0] col_oe_o;
    logic [3:0] row_i;
    logic       strobe_n = 1'b1;
    logic       irq_o;

    logic       key_on = 1'b0;
    int         kr = 0;
    int         kc = 0;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Key model: the pressed key pulls its row low while its column is driven low.
    always_comb begin
        row_i = 4'hF;
        if (key_on && col_o[3-kc] == 1'b0) row_i[kr] = 1'b0;
    end

    kpd_scan_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .col_o(col_o), .col_oe_o(col_oe_o),
        .row_i(row_i), .strobe_n_i(strobe_n), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_code(input int r, input int c);
        logic [3:0] rn, cn;
        rn = 4'hF; rn[r] = 1'b0;
        cn = 4'hF; cn[3-c] = 1'b0;
        return {rn, cn};
    endfunction

    function automatic int exp_time(input int steps, input int s);
        return 3 + steps * (s + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_sel = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_sel = a; #1 d = reg_rdata;
    endtask

    // Poll status each falling edge until busy has risen and fallen; return edges since t0.
    task automatic wait_done(input int t0, input bit pulse_only, output int dt);
        logic [7:0] s;
        int guard = 0;
        do begin
            @(negedge clk); #1;
            if (pulse_only && cyc - t0 >= 4) strobe_n = 1'b1;
            peek(2'd0, s);
            guard++;
        end while ((s[4] || cyc - t0 <= 3) && guard < 3000);
        dt = cyc - t0;
    endtask

    task automatic release_key();
        @(negedge clk); key_on = 1'b0; strobe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v, last_code;
        int t0, dt;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk(col_o == 4'h0, "R1 col_o", col_o, 0);
        chk(col_oe_o == 4'h0, "R1 col_oe_o", col_oe_o, 0);
        chk(irq_o == 1'b0, "R1 irq_o", irq_o, 0);
        peek(2'd0, v); chk(v == 8'h00, "R1 status", v, 0);
        peek(2'd1, v); chk(v == 8'hFF, "R1 data", v, 8'hFF);
        peek(2'd2, v); chk(v == 8'd4, "R1 settle", v, 4);

        // R2 direction register and idle columns
        wr(2'd3, 8'hFA);
        #1 chk(col_oe_o == 4'hA, "R2 col_oe_o", col_oe_o, 4'hA);
        peek(2'd3, v); chk(v == 8'h0A, "R2 dir readback", v, 8'h0A);
        chk(col_o == 4'h0, "R2 idle cols", col_o, 0);

        // R3 R6 R7: leftmost column, row 2 -> 1011_0111; flag and busy 3 edges after strobe
        wr(2'd2, 8'd3);
        @(negedge clk); key_on = 1'b1; kr = 2; kc = 0; strobe_n = 1'b0; t0 = cyc;
        repeat (2) @(negedge clk); #1;
        peek(2'd0, v); chk(v[7] == 1'b0, "R3 flag not yet at 2 edges", v, 0);
        @(negedge clk); #1;
        peek(2'd0, v); chk(v[7] && v[4], "R3 flag and busy at 3 edges", v, 8'h90);
        chk(col_o == 4'b0111, "R6 step 0 pattern", col_o, 4'b0111);
        chk(irq_o == 1'b0, "R4 irq off with enable clear", irq_o, 0);
        wait_done(t0, 1'b0, dt);
        chk(dt == exp_time(1, 3), "R7 completion time", dt, exp_time(1, 3));
        peek(2'd1, v); chk(v == 8'hB7, "R7 code", v, 8'hB7);
        peek(2'd0, v); chk(v[6] && !v[5], "R7 key found bit", v, 8'hC0);
        chk(col_o == 4'h0, "R2 cols back low", col_o, 0);

        // R4 enable raises irq; R5 data read alone keeps flag
        wr(2'd0, 8'h01);
        #1 chk(irq_o == 1'b1, "R4 irq with flag and enable", irq_o, 1);
        rd(2'd1, v); #1;
        chk(irq_o == 1'b1, "R5 data read alone keeps flag", irq_o, 1);
        rd(2'd0, v); rd(2'd1, v); #1;
        chk(irq_o == 1'b0, "R5 status then data clears flag", irq_o, 0);
        peek(2'd0, v); chk(v[7] == 1'b0, "R5 flag bit", v, 0);
        release_key();
        last_code = 8'hB7;

        // R8 no-key scan, R10 status bits cleared on start
        wr(2'd2, 8'd2);
        @(negedge clk); strobe_n = 1'b0; t0 = cyc;
        repeat (3) @(negedge clk); #1;
        peek(2'd0, v); chk(v[6] == 1'b0 && v[5] == 1'b0, "R10 result bits cleared", v, 8'h91);
        wait_done(t0, 1'b1, dt);
        chk(dt == exp_time(4, 2), "R8 no-key time", dt, exp_time(4, 2));
        peek(2'd0, v); chk(v[5] && !v[6], "R8 no-key bit", v, 8'hA1);
        peek(2'd1, v); chk(v == last_code, "R8 data unchanged", v, last_code);
        chk(col_o == 4'h0, "R8 cols low", col_o, 0);
        rd(2'd0, v); rd(2'd1, v);
        release_key();

        // R9 strobe edge during scan ignored
        wr(2'd2, 8'd10);
        @(negedge clk); key_on = 1'b1; kr = 0; kc = 3; strobe_n = 1'b0; t0 = cyc;
        repeat (5) @(negedge clk);
        rd(2'd0, v); rd(2'd1, v);
        @(negedge clk); strobe_n = 1'b1;
        repeat (3) @(negedge clk); strobe_n = 1'b0;
        wait_done(t0, 1'b0, dt);
        chk(dt == exp_time(4, 10), "R9 scan not restarted", dt, exp_time(4, 10));
        peek(2'd0, v); chk(v[7] == 1'b0, "R9 flag stays clear", v, 0);
        chk(irq_o == 1'b0, "R9 no irq", irq_o, 0);
        peek(2'd1, v); chk(v == exp_code(0, 3), "R7 code col 3", v, exp_code(0, 3));
        release_key();

        // Random keys and settle counts
        for (int i = 0; i < 24; i++) begin
            int r, c, s;
            bit en;
            r = $urandom_range(0, 3); c = $urandom_range(0, 3);
            s = $urandom_range(2, 7); en = $urandom_range(0, 1);
            wr(2'd2, 8'(s));
            wr(2'd0, {7'd0, en});
            @(negedge clk); key_on = 1'b1; kr = r; kc = c; strobe_n = 1'b0; t0 = cyc;
            wait_done(t0, 1'b0, dt);
            chk(dt == exp_time(c + 1, s), "R7 random timing", dt, exp_time(c + 1, s));
            peek(2'd1, v); chk(v == exp_code(r, c), "R7 random code", v, exp_code(r, c));
            #1 chk(irq_o == en, "R4 random irq", irq_o, en);
            rd(2'd0, v); rd(2'd1, v);
            release_key();
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule